// File: doc/BRIEF.md
# VBI Ancillary Packet Formatter

This block turns one line of sliced vertical-blanking data into an ancillary data packet on an 8-bit video output. A start pulse marks the position just after the end-of-active-video code. The block then sends a byte stream made of four parts: an 8-byte header, the payload, a one-byte checksum, and zero fill. The fill pads the packet to a whole number of 4-byte dwords.

Line attributes are sampled on the accepted start pulse. These are the field, whether the line lies inside the blanking interval, the 10-bit line number, the 6-bit format code, the two match flags, the error flag and the payload length. Payload bytes come through a combinational read port: the block presents a byte index and takes the addressed byte in the same cycle. A packet is produced only while ancillary output is selected. When it is not selected, the sliced data is expected to go to a FIFO path elsewhere, and the formatter stays silent.

Top module: `vbi_anc_packer`

## Requirements
- R1: After reset `anc_valid` is 0. A start accepted at a clock edge (start=1, anc_sel=1, not busy) makes byte 0 valid in the next cycle. Bytes 0, 1 and 2 are 0x00, 0xFF and 0xFF.
- R2: Byte 3 is the data ID: 0x91 for field 1 inside blanking, 0x53 for field 1 outside blanking, 0x55 for field 2 inside blanking, and 0x97 for field 2 outside blanking. `fld_in`=0 means field 1; `vbi_in`=1 means inside blanking.
- R3: Bytes 3, 4 and 5 carry a 6-bit value in bits 5:0. Bit 6 is the XOR of bits 5:0, so that the seven bits have even parity. Bit 7 is the inverse of bit 6.
- R4: Byte 4 carries the format code in bits 5:0. Byte 5 carries N = ceil((L+9)/4) − 2 in bits 5:0, where L is the payload length.
- R5: Byte 6 is line number bits 7:0. Byte 7 holds line bits 9:8 in bits 1:0, the match-2 flag in bit 2, the match-1 flag in bit 3 and the error flag in bit 4; bits 7:5 are 0.
- R6: Bytes 8 to 7+L are the payload bytes in index order. During byte 8+i, `pay_rd`=1 and `pay_idx`=i.
- R7: Byte 8+L is the 8-bit modulo sum of the L payload bytes.
- R8: The bytes after the checksum are 0x00. `anc_valid` stays high for exactly 4N+8 consecutive cycles and then drops.
- R9: A start pulse while a packet is in progress is ignored, and the packet in flight is unchanged.
- R10: While anc_sel=0, a start pulse produces no output.
- R11: Payload lengths from 0 to MAX_PAY are supported, and each gives the packet length stated in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| anc_sel | input | 1 | 1 selects ancillary output of sliced data |
| start | input | 1 | Pulse at the position just after end-of-active-video |
| fld_in | input | 1 | Field of the line (0 = field 1) |
| vbi_in | input | 1 | 1 when the line lies inside the blanking interval |
| line_in | input | 10 | Video line number |
| fmt_in | input | 6 | Line data format code |
| m1_in | input | 1 | Match-1 flag |
| m2_in | input | 1 | Match-2 flag |
| err_in | input | 1 | Single error detected flag |
| pay_len | input | 7 | Payload length L in bytes (0..MAX_PAY) |
| pay_idx | output | 6 | Index of the payload byte requested |
| pay_rd | output | 1 | High while a payload byte is being consumed |
| pay_data | input | 8 | Payload byte at `pay_idx`, valid in the same cycle |
| anc_valid | output | 1 | Qualifies `anc_byte` |
| anc_byte | output | 8 | Packet byte stream |
| busy | output | 1 | A packet is in progress |

## Verification
The assertions assume two things about the inputs. `pay_len` never exceeds MAX_PAY when a start is accepted. `pay_data` settles combinationally from `pay_idx` within the cycle. The stimulus keeps within both limits. It sweeps every length from 0 to MAX_PAY and supplies payload bytes from an arithmetic function of the index, evaluated at the falling edge. Across the sweep it rotates through all four field/blanking combinations, and it varies the line number, the format code and the flags. It also pulses start in the middle of a packet, and it pulses start with ancillary output deselected, to confirm both are ignored.

// File: rtl/vbi_anc_pkg.sv
// Package: shared types and the 6-bit parity-protect encoder for the
// ancillary packet formatter. Assumes nothing beyond its callers.
package vbi_anc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_PAY,
        PH_SUM,
        PH_FILL
    } anc_phase_t;

    // Protect a 6-bit value: bit6 = even parity bit, bit7 = its inverse.
    function automatic logic [7:0] prot6(input logic [5:0] v);
        return {~(^v), ^v, v};
    endfunction
endpackage

// File: rtl/anc_len.sv
// Length calculator: from the payload length L it derives the dword count
// N = ceil((L+9)/4)-2 and the whole packet length 4N+8.
// Assumes L <= MAX_PAY so that N fits in 6 bits.
module anc_len #(
    parameter int LEN_W = 7,
    parameter int IDX_W = 9
) (
    input  logic [LEN_W-1:0] len,
    output logic [5:0]       dwords,
    output logic [IDX_W-1:0] total
);
    localparam int SUM_W = IDX_W;

    logic [SUM_W-1:0] padded;

    // Round L+9 up to a multiple of 4, i.e. floor((L+12)/4)*4.
    always_comb begin
        padded = SUM_W'(len) + SUM_W'(12);
        total  = {padded[SUM_W-1:2], 2'b00};
        dwords = 6'(padded[SUM_W-1:2] - 2);
    end
endmodule

// File: rtl/anc_hdr.sv
// Header byte generator: returns header byte 0..7 for the captured line
// attributes. Assumes the caller only uses it while idx < 8.
module anc_hdr
    import vbi_anc_pkg::*;
(
    input  logic [2:0] idx,
    input  logic       fld,
    input  logic       vbi,
    input  logic [9:0] line,
    input  logic [5:0] fmt,
    input  logic       m1,
    input  logic       m2,
    input  logic       err,
    input  logic [5:0] dwords,
    output logic [7:0] hbyte
);
    logic [5:0] did6;

    // Data ID low bits: 010 prefix, then field, outside-blanking, 1.
    always_comb did6 = {3'b010, fld, ~vbi, 1'b1};

    // Select the header byte at position idx.
    always_comb begin
        case (idx)
            3'd0:    hbyte = 8'h00;
            3'd1:    hbyte = 8'hFF;
            3'd2:    hbyte = 8'hFF;
            3'd3:    hbyte = prot6(did6);
            3'd4:    hbyte = prot6(fmt);
            3'd5:    hbyte = prot6(dwords);
            3'd6:    hbyte = line[7:0];
            default: hbyte = {3'b000, err, m1, m2, line[9:8]};
        endcase
    end
endmodule

// File: rtl/anc_sum.sv
// Checksum accumulator: clears on packet start and adds each consumed
// payload byte modulo 256. Assumes clr and add are never high together.
module anc_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] sum
);
    // Running modulo-256 sum of the payload.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= 8'h00;
        else if (add)      sum <= sum + din;
    end
endmodule

// File: rtl/vbi_anc_packer.sv
// Top: sequences one ancillary packet per accepted start pulse.
// The packet is a header, the payload, a checksum and zero fill up to a
// multiple of 4 bytes. Output bytes come from a combinational mux on the
// byte index, so byte 0 is valid the cycle after start is accepted.
// Assumes pay_data follows pay_idx within the cycle and pay_len <= MAX_PAY.
module vbi_anc_packer
    import vbi_anc_pkg::*;
#(
    parameter int MAX_PAY = 64,
    localparam int LEN_W  = $clog2(MAX_PAY + 1),
    localparam int ADDR_W = $clog2(MAX_PAY),
    localparam int IDX_W  = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              anc_sel,
    input  logic              start,
    input  logic              fld_in,
    input  logic              vbi_in,
    input  logic [9:0]        line_in,
    input  logic [5:0]        fmt_in,
    input  logic              m1_in,
    input  logic              m2_in,
    input  logic              err_in,
    input  logic [LEN_W-1:0]  pay_len,
    output logic [ADDR_W-1:0] pay_idx,
    output logic              pay_rd,
    input  logic [7:0]        pay_data,
    output logic              anc_valid,
    output logic [7:0]        anc_byte,
    output logic              busy
);
    logic             fld_q, vbi_q, m1_q, m2_q, err_q;
    logic [9:0]       line_q;
    logic [5:0]       fmt_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic [5:0]       dwords;
    logic [IDX_W-1:0] total;
    logic [IDX_W-1:0] sum_pos;
    logic [7:0]       hbyte;
    logic [7:0]       csum;
    anc_phase_t       phase;

    assign accept = start && anc_sel && !busy;

    // Capture the line attributes on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q  <= 1'b0;
            vbi_q  <= 1'b0;
            m1_q   <= 1'b0;
            m2_q   <= 1'b0;
            err_q  <= 1'b0;
            line_q <= '0;
            fmt_q  <= '0;
            len_q  <= '0;
        end else if (accept) begin
            fld_q  <= fld_in;
            vbi_q  <= vbi_in;
            m1_q   <= m1_in;
            m2_q   <= m2_in;
            err_q  <= err_in;
            line_q <= line_in;
            fmt_q  <= fmt_in;
            len_q  <= pay_len;
        end
    end

    // Byte index and busy flag: run from 0 to total-1, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == total - IDX_W'(1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    anc_len #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_len (
        .len    (len_q),
        .dwords (dwords),
        .total  (total)
    );

    anc_hdr u_hdr (
        .idx    (idx[2:0]),
        .fld    (fld_q),
        .vbi    (vbi_q),
        .line   (line_q),
        .fmt    (fmt_q),
        .m1     (m1_q),
        .m2     (m2_q),
        .err    (err_q),
        .dwords (dwords),
        .hbyte  (hbyte)
    );

    anc_sum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .add   (pay_rd),
        .din   (pay_data),
        .sum   (csum)
    );

    // Phase decode from the byte index and the captured length.
    always_comb begin
        sum_pos = IDX_W'(len_q) + IDX_W'(8);
        if (!busy)              phase = PH_IDLE;
        else if (idx < IDX_W'(8)) phase = PH_HDR;
        else if (idx < sum_pos) phase = PH_PAY;
        else if (idx == sum_pos) phase = PH_SUM;
        else                    phase = PH_FILL;
    end

    // Payload read port and output byte mux.
    always_comb begin
        pay_rd    = (phase == PH_PAY);
        pay_idx   = ADDR_W'(idx - IDX_W'(8));
        anc_valid = busy;
        case (phase)
            PH_HDR:  anc_byte = hbyte;
            PH_PAY:  anc_byte = pay_data;
            PH_SUM:  anc_byte = csum;
            default: anc_byte = 8'h00;
        endcase
    end

    // R1: an accepted start puts the zero preamble byte out next cycle.
    a_r1_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (anc_valid && anc_byte == 8'h00));

    // R3: protected header bytes carry even parity and its inverse.
    a_r3_hdr_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HDR && idx >= IDX_W'(3) && idx <= IDX_W'(5)) |->
        (anc_byte[7] != anc_byte[6] && anc_byte[6] == ^anc_byte[5:0]));

    // R8: fill bytes are zero.
    a_r8_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL) |-> (anc_byte == 8'h00));

    // R9: a start during a packet leaves the captured length untouched.
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

    // R10: with ancillary output deselected an idle block stays silent.
    a_r10_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !anc_sel) |=> !anc_valid);

    // R11: accepted lengths stay within the supported range.
    a_r11_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (pay_len <= LEN_W'(MAX_PAY)));
endmodule

// File: tb/sim_vbi_anc_packer.sv
`timescale 1ns/1ps
module sim_vbi_anc_packer;
    localparam int MAX_PAY = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       anc_sel = 1'b0;
    logic       start = 1'b0;
    logic       fld_in = 1'b0, vbi_in = 1'b0;
    logic [9:0] line_in = '0;
    logic [5:0] fmt_in = '0;
    logic       m1_in = 1'b0, m2_in = 1'b0, err_in = 1'b0;
    logic [6:0] pay_len = '0;
    logic [5:0] pay_idx;
    logic       pay_rd;
    logic [7:0] pay_data;
    logic       anc_valid;
    logic [7:0] anc_byte;
    logic       busy;
    logic [7:0] seed = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    // Payload source: arithmetic function of the requested index.
    assign pay_data = 8'(pay_idx * 8'd13) + seed;

    vbi_anc_packer #(.MAX_PAY(MAX_PAY)) u0 (
        .clk(clk), .rst_n(rst_n), .anc_sel(anc_sel), .start(start),
        .fld_in(fld_in), .vbi_in(vbi_in), .line_in(line_in), .fmt_in(fmt_in),
        .m1_in(m1_in), .m2_in(m2_in), .err_in(err_in), .pay_len(pay_len),
        .pay_idx(pay_idx), .pay_rd(pay_rd), .pay_data(pay_data),
        .anc_valid(anc_valid), .anc_byte(anc_byte), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] prot(input logic [5:0] v);
        int ones = 0;
        for (int b = 0; b < 6; b++) ones += v[b];
        return {(ones % 2 == 0), (ones % 2 == 1), v};
    endfunction

    function automatic logic [7:0] pay_at(input int i, input logic [7:0] s);
        return 8'((i * 13) % 64 * 0 + (i * 13)) + s;
    endfunction

    // Send one packet and check every byte; optionally poke start mid-packet.
    task automatic run_pkt(input int len, input bit f, input bit v, input int ln,
                           input int fm, input bit a1, input bit a2, input bit e,
                           input bit poke);
        int n, tot;
        logic [7:0] did, exp, cs;
        string req;
        n   = (len + 9 + 3) / 4 - 2;
        tot = 4 * n + 8;
        case ({f, v})
            2'b01:   did = 8'h91;
            2'b00:   did = 8'h53;
            2'b11:   did = 8'h55;
            default: did = 8'h97;
        endcase
        cs = 8'h00;
        for (int i = 0; i < len; i++) cs = cs + pay_at(i, seed);
        fld_in = f; vbi_in = v; line_in = 10'(ln); fmt_in = 6'(fm);
        m1_in = a1; m2_in = a2; err_in = e; pay_len = 7'(len);
        anc_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < tot; k++) begin
            if (k < 3)            begin exp = (k == 0) ? 8'h00 : 8'hFF; req = "R1"; end
            else if (k == 3)      begin exp = did; req = "R2"; end
            else if (k == 4)      begin exp = prot(6'(fm)); req = "R4"; end
            else if (k == 5)      begin exp = prot(6'(n)); req = "R4"; end
            else if (k == 6)      begin exp = 8'(ln); req = "R5"; end
            else if (k == 7)      begin exp = {3'b0, e, a1, a2, 2'(ln >> 8)}; req = "R5"; end
            else if (k < 8 + len) begin exp = pay_at(k - 8, seed); req = "R6"; end
            else if (k == 8 + len) begin exp = cs; req = "R7"; end
            else                  begin exp = 8'h00; req = "R8"; end
            chk(anc_valid && anc_byte == exp, req, {anc_valid, anc_byte}, {1'b1, exp});
            if (k >= 3 && k <= 5)
                chk(anc_byte[7] == ~anc_byte[6] && anc_byte[6] == ^anc_byte[5:0],
                    "R3", anc_byte, prot(anc_byte[5:0]));
            if (k >= 8 && k < 8 + len)
                chk(pay_rd && pay_idx == 6'(k - 8), "R6", pay_idx, k - 8);
            if (poke && k == 5) begin
                start = 1'b1; pay_len = 7'd3; fld_in = ~f; fmt_in = 6'h2A;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(!anc_valid, "R8", anc_valid, 0);
        chk(!busy, "R11", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!anc_valid && !busy, "R1", {anc_valid, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep every payload length across field/blanking combinations.
        for (int len = 0; len <= MAX_PAY; len++) begin
            seed = 8'(len * 29 + 7);
            run_pkt(len, len[1], len[0], (len * 37 + 5) % 1024, (len * 5) % 64,
                    len[2], len[3], len[4], len == 20);
            repeat (len % 3) @(negedge clk);
        end
        // R9: start pulses throughout a packet are ignored.
        seed = 8'h5A;
        run_pkt(43, 1'b0, 1'b1, 1023, 63, 1'b1, 1'b1, 1'b1, 1'b1);
        // R10: deselected ancillary output ignores start.
        anc_sel = 1'b0; start = 1'b1; pay_len = 7'd2;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            chk(!anc_valid && !busy, "R10", {anc_valid, busy}, 0);
            @(negedge clk);
        end
        // Back-to-back start right after a packet ends.
        run_pkt(2, 1'b1, 1'b1, 21, 7, 1'b0, 1'b0, 1'b0, 1'b0);
        run_pkt(0, 1'b0, 1'b0, 512, 1, 1'b0, 1'b1, 1'b0, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule